// File: doc/BRIEF.md
# Half-Word to Word Register Access Bridge

This block connects a 16-bit register bus to a bank of 32-bit registers, so that software on the narrow bus sees each 32-bit register as one coherent value. A 32-bit register is reached through two half-word addresses. Bit 1 of the bus address selects the upper or lower half, and the two halves share one word address.

Writes are staged. A store to the lower half only parks its 16 bits inside the bridge. A later store to the upper half joins those bits with its own and sends a single 32-bit write to the register bank. Reads run the other way. A load from the lower half fetches the whole 32-bit word, returns its low 16 bits and keeps the high 16 bits aside. A later load from the upper half returns that kept copy and does not touch the register bank. Software that reads low then high therefore sees one snapshot, even when the register changes between the two accesses.

Byte-wide accesses are refused and flagged. A cycle that asserts read and write together is also refused and flagged. Register decoding behind the word port belongs to the register bank, not to this bridge.

Top module: `half_word_reg_bridge`

## Requirements
- R1: After reset, `reg_we`, `reg_re`, `bus_err` and `bus_rdata` are 0, the parked lower half is 0 and the kept upper half is 0. An upper-half store straight after reset therefore writes 0 in bits 15:0, and an upper-half load straight after reset returns 0.
- R2: A 16-bit store with address bit 1 = 0 does not raise `reg_we`. It only replaces the parked lower half.
- R3: A 16-bit store with address bit 1 = 1, sampled at clock edge t, raises `reg_we` for exactly the cycle after edge t. In that cycle `reg_wdata` = {bus data, parked lower half} and `reg_addr` is the bus address with bit 1 cleared.
- R4: A 16-bit load with address bit 1 = 0, sampled at edge t, raises `reg_re` for the cycle after edge t, with `reg_addr` equal to the bus address with bit 1 cleared. The word on `reg_rdata` in that cycle is captured at edge t+1. Its bits 15:0 appear on `bus_rdata` and its bits 31:16 are kept as the upper half.
- R5: A 16-bit load with address bit 1 = 1, sampled at edge t, never raises `reg_re`. After edge t+1 `bus_rdata` holds the kept upper half. That value includes a lower-half load issued in the cycle just before.
- R6: A cycle with read or write asserted together with `bus_byte` = 1 raises `bus_err` for the cycle after its edge. It raises neither `reg_we` nor `reg_re`, and it leaves the parked lower half, the kept upper half and `bus_rdata` unchanged.
- R7: A cycle with `bus_rd` and `bus_wr` both asserted is treated like R6: it raises `bus_err` and has no other effect.
- R8: `reg_we` and `reg_re` are never high in the same cycle. After an isolated lower-half load, `reg_re` is high for one cycle only.
- R9: `bus_rdata` changes only at the edge that completes an accepted 16-bit load. Between loads it holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the narrow access; bit 1 selects the half |
| bus_wdata | input | HALF_W | Store data from the narrow bus |
| bus_rd | input | 1 | Load strobe, one cycle per access |
| bus_wr | input | 1 | Store strobe, one cycle per access |
| bus_byte | input | 1 | 1 marks a byte-wide access, which is refused |
| bus_rdata | output | HALF_W | Load result, held until the next accepted load |
| bus_err | output | 1 | One-cycle flag for a refused access |
| reg_addr | output | ADDR_W | Word address toward the register bank |
| reg_wdata | output | 2*HALF_W | Merged word for the register bank |
| reg_we | output | 1 | One-cycle word write strobe |
| reg_re | output | 1 | One-cycle word read strobe |
| reg_rdata | input | 2*HALF_W | Word returned by the register bank during `reg_re` |

## Verification
Every strobe and the error flag come from a register loaded at the edge that samples the access. The bench drives inputs on falling edges and reads `reg_we`, `reg_re`, `reg_addr`, `reg_wdata` and `bus_err` on the next falling edge. Load results settle one edge later. For both halves, `bus_rdata` is sampled on the falling edge after that second rising edge. A low-then-high load pair issued back to back is checked on two consecutive falling edges. This shows that the second result comes from the snapshot taken by the first.

// File: rtl/hwb_pkg.sv
package hwb_pkg;

  typedef enum logic [2:0] {
    ACC_IDLE  = 3'd0,
    ACC_WR_LO = 3'd1,
    ACC_WR_HI = 3'd2,
    ACC_RD_LO = 3'd3,
    ACC_RD_HI = 3'd4,
    ACC_BAD   = 3'd5
  } acc_kind_e;

  // Sort one bus cycle into the action the bridge takes for it.
  function automatic acc_kind_e classify(input logic rd, input logic wr,
                                         input logic byte_acc, input logic hi);
    acc_kind_e k;
    if (!rd && !wr)                k = ACC_IDLE;
    else if (byte_acc || (rd && wr)) k = ACC_BAD;
    else if (wr)                   k = hi ? ACC_WR_HI : ACC_WR_LO;
    else                           k = hi ? ACC_RD_HI : ACC_RD_LO;
    return k;
  endfunction

  function automatic logic is_word_access(input acc_kind_e k);
    return (k == ACC_WR_HI) || (k == ACC_RD_LO);
  endfunction

  function automatic logic is_good_read(input acc_kind_e k);
    return (k == ACC_RD_LO) || (k == ACC_RD_HI);
  endfunction

endpackage

// File: rtl/hwb_access_decode.sv
module hwb_access_decode
  import hwb_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int HALF_SEL = 1
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_byte,
  output acc_kind_e         kind,
  output logic              ev_word,
  output logic              ev_bad,
  output logic [ADDR_W-1:0] word_addr
);

  localparam logic [ADDR_W-1:0] HALF_MASK = ADDR_W'(1) << HALF_SEL;

  function automatic logic [ADDR_W-1:0] to_word(input logic [ADDR_W-1:0] a);
    return a & ~HALF_MASK;
  endfunction

  always_comb begin
    kind      = classify(bus_rd, bus_wr, bus_byte, bus_addr[HALF_SEL]);
    ev_word   = is_word_access(kind);
    ev_bad    = (kind == ACC_BAD);
    word_addr = to_word(bus_addr);
  end

endmodule

// File: rtl/hwb_write_stage.sv
module hwb_write_stage
  import hwb_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  acc_kind_e           kind,
  input  logic [HALF_W-1:0]   wdata,
  output logic [HALF_W-1:0]   held_lo,
  output logic                we_q,
  output logic [2*HALF_W-1:0] word_q
);

  localparam int WORD_W = 2 * HALF_W;

  function automatic logic [WORD_W-1:0] merge(input logic [HALF_W-1:0] hi,
                                              input logic [HALF_W-1:0] lo);
    return {hi, lo};
  endfunction

  logic park_lo;
  logic commit;

  assign park_lo = (kind == ACC_WR_LO);
  assign commit  = (kind == ACC_WR_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_lo <= '0;
    end else if (park_lo) begin
      held_lo <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      word_q <= '0;
    end else begin
      we_q <= commit;
      if (commit) word_q <= merge(wdata, held_lo);
    end
  end

endmodule

// File: rtl/hwb_read_stage.sv
module hwb_read_stage
  import hwb_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  acc_kind_e           kind,
  input  logic [2*HALF_W-1:0] word_in,
  output logic                re_q,
  output logic                rd_pend,
  output logic [HALF_W-1:0]   kept_hi,
  output logic [HALF_W-1:0]   rdata_q
);

  localparam int WORD_W = 2 * HALF_W;

  function automatic logic [HALF_W-1:0] low_of(input logic [WORD_W-1:0] w);
    return w[HALF_W-1:0];
  endfunction

  function automatic logic [HALF_W-1:0] high_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:HALF_W];
  endfunction

  logic pend_lo;

  // Stage 1: issue the word read for low loads, remember which half is due.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      re_q    <= 1'b0;
      rd_pend <= 1'b0;
      pend_lo <= 1'b0;
    end else begin
      re_q    <= (kind == ACC_RD_LO);
      rd_pend <= is_good_read(kind);
      pend_lo <= (kind == ACC_RD_LO);
    end
  end

  // Stage 2: capture the word, or serve the kept upper half.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kept_hi <= '0;
      rdata_q <= '0;
    end else if (rd_pend) begin
      if (pend_lo) begin
        rdata_q <= low_of(word_in);
        kept_hi <= high_of(word_in);
      end else begin
        rdata_q <= kept_hi;
      end
    end
  end

endmodule

// File: rtl/half_word_reg_bridge.sv
module half_word_reg_bridge
  import hwb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [HALF_W-1:0]   bus_wdata,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic                bus_byte,
  output logic [HALF_W-1:0]   bus_rdata,
  output logic                bus_err,
  output logic [ADDR_W-1:0]   reg_addr,
  output logic [2*HALF_W-1:0] reg_wdata,
  output logic                reg_we,
  output logic                reg_re,
  input  logic [2*HALF_W-1:0] reg_rdata
);

  localparam int HALF_SEL = $clog2(HALF_W / 8);

  acc_kind_e         kind;
  logic              ev_word;
  logic              ev_bad;
  logic [ADDR_W-1:0] word_addr;
  logic [HALF_W-1:0] held_lo;
  logic [HALF_W-1:0] kept_hi;
  logic              rd_pend;

  hwb_access_decode #(
    .ADDR_W   (ADDR_W),
    .HALF_SEL (HALF_SEL)
  ) u_decode (
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_byte  (bus_byte),
    .kind      (kind),
    .ev_word   (ev_word),
    .ev_bad    (ev_bad),
    .word_addr (word_addr)
  );

  hwb_write_stage #(
    .HALF_W (HALF_W)
  ) u_write (
    .clk     (clk),
    .rst_n   (rst_n),
    .kind    (kind),
    .wdata   (bus_wdata),
    .held_lo (held_lo),
    .we_q    (reg_we),
    .word_q  (reg_wdata)
  );

  hwb_read_stage #(
    .HALF_W (HALF_W)
  ) u_read (
    .clk     (clk),
    .rst_n   (rst_n),
    .kind    (kind),
    .word_in (reg_rdata),
    .re_q    (reg_re),
    .rd_pend (rd_pend),
    .kept_hi (kept_hi),
    .rdata_q (bus_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_addr <= '0;
      bus_err  <= 1'b0;
    end else begin
      bus_err <= ev_bad;
      if (ev_word) reg_addr <= word_addr;
    end
  end

endmodule

// File: rtl/hwb_checker.sv
module hwb_checker #(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              bus_byte,
  input logic              bus_hi,
  input logic              reg_we,
  input logic              reg_re,
  input logic              bus_err,
  input logic              rd_pend,
  input logic [HALF_W-1:0] bus_rdata,
  input logic [HALF_W-1:0] held_lo
);

  logic good_wr_lo, good_wr_hi, good_rd_lo;
  assign good_wr_lo = bus_wr && !bus_rd && !bus_byte && !bus_hi;
  assign good_wr_hi = bus_wr && !bus_rd && !bus_byte && bus_hi;
  assign good_rd_lo = bus_rd && !bus_wr && !bus_byte && !bus_hi;

  assert_lo_store_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    good_wr_lo |=> !reg_we);

  assert_we_from_hi_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(good_wr_hi));

  assert_hi_store_writes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    good_wr_hi |=> reg_we);

  assert_re_from_lo_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |-> $past(good_rd_lo));

  assert_hi_load_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && !bus_byte && bus_hi) |=> !reg_re);

  assert_byte_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_byte && (bus_rd || bus_wr)) |=> (bus_err && !reg_we && !reg_re));

  assert_byte_keeps_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_byte && bus_wr) |=> $stable(held_lo));

  assert_both_strobes_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_wr) |=> (bus_err && !reg_we && !reg_re));

  assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_we, reg_re, bus_err}));

  assert_rdata_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_pend |=> $stable(bus_rdata));

endmodule

bind half_word_reg_bridge hwb_checker #(
  .ADDR_W (ADDR_W),
  .HALF_W (HALF_W)
) u_hwb_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_byte  (bus_byte),
  .bus_hi    (bus_addr[HALF_SEL]),
  .reg_we    (reg_we),
  .reg_re    (reg_re),
  .bus_err   (bus_err),
  .rd_pend   (rd_pend),
  .bus_rdata (bus_rdata),
  .held_lo   (held_lo)
);

// File: tb/test_half_word_reg_bridge.sv
module test_half_word_reg_bridge;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int HW = 16;
  localparam int NVEC = 14;

  // kind: 0 store low, 1 store high, 2 load low, 3 load high; data = store value or expected load result
  localparam logic [25:0] VEC [0:NVEC-1] = '{
    {2'd0, 8'h00, 16'h1111}, {2'd1, 8'h02, 16'h2222},
    {2'd0, 8'h04, 16'hA5A5}, {2'd1, 8'h06, 16'h5A5A},
    {2'd0, 8'h08, 16'hBEEF}, {2'd1, 8'h0A, 16'hDEAD},
    {2'd2, 8'h04, 16'hA5A5}, {2'd3, 8'h06, 16'h5A5A},
    {2'd2, 8'h08, 16'hBEEF}, {2'd3, 8'h0A, 16'hDEAD},
    {2'd3, 8'h02, 16'hDEAD}, {2'd2, 8'h00, 16'h1111},
    {2'd3, 8'h02, 16'h2222}, {2'd1, 8'h0E, 16'h7777}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [HW-1:0] bus_wdata = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0, bus_byte = 1'b0;
  logic [HW-1:0] bus_rdata;
  logic bus_err;
  logic [AW-1:0] reg_addr;
  logic [2*HW-1:0] reg_wdata;
  logic reg_we, reg_re;
  logic [2*HW-1:0] reg_rdata;

  logic [2*HW-1:0] bank [0:3];
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  logic o_we, o_re, o_err, o_re2;
  logic [AW-1:0] o_addr;
  logic [2*HW-1:0] o_wdata;
  logic [HW-1:0] o_rdata;
  logic [HW-1:0] last_lo = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  half_word_reg_bridge #(.ADDR_W(AW), .HALF_W(HW)) i_half_word_reg_bridge (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_byte(bus_byte),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  // Register bank model behind the word port.
  assign reg_rdata = bank[reg_addr[3:2]];
  always @(posedge clk) if (reg_we) bank[reg_addr[3:2]] <= reg_wdata;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected below 5000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // R8: the two word strobes never overlap
  always @(negedge clk) if (rst_n && reg_we && reg_re) begin
    errors++;
    $display("FAIL R8: reg_we and reg_re both high, actual 11 expected not both");
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input logic rd, input logic wr, input logic byt,
                    input logic [AW-1:0] a, input logic [HW-1:0] d);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_byte = byt; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; bus_byte = 0;
    o_we = reg_we; o_re = reg_re; o_err = bus_err; o_addr = reg_addr; o_wdata = reg_wdata;
    @(negedge clk);
    o_re2 = reg_re; o_rdata = bus_rdata;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) bank[i] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk("R1 reg_we", reg_we, 0);
    chk("R1 reg_re", reg_re, 0);
    chk("R1 bus_err", bus_err, 0);
    chk("R1 bus_rdata", bus_rdata, 0);
    rst_n = 1'b1;

    // R1: kept upper half and parked lower half start at zero
    op(1, 0, 0, 8'h0A, 0);
    chk("R1 kept upper after reset", o_rdata, 16'h0000);
    op(0, 1, 0, 8'h02, 16'h1234);
    chk("R1 parked lower after reset", o_wdata, 32'h1234_0000);

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] k;
      logic [AW-1:0] a;
      logic [HW-1:0] d;
      {k, a, d} = VEC[i];
      op(k[1], !k[1], 0, a, d);
      case (k)
        2'd0: begin
          chk("R2 low store no write", o_we, 0);
          last_lo = d;
        end
        2'd1: begin
          chk("R3 write strobe", o_we, 1);
          chk("R3 merged word", o_wdata, {d, last_lo});
          chk("R3 word address", o_addr, a & 8'hFD);
        end
        2'd2: begin
          chk("R4 read strobe", o_re, 1);
          chk("R4 word address", o_addr, a & 8'hFD);
          chk("R4 low result", o_rdata, d);
          chk("R8 single read pulse", o_re2, 0);
        end
        default: begin
          chk("R5 no read strobe", o_re, 0);
          chk("R5 kept upper result", o_rdata, d);
        end
      endcase
    end

    // R6: byte store refused, parked lower half unchanged
    op(0, 1, 1, 8'h0C, 16'h0BAD);
    chk("R6 byte store error", o_err, 1);
    chk("R6 byte store no write", o_we, 0);
    op(0, 1, 0, 8'h0E, 16'h4444);
    chk("R6 parked lower kept", o_wdata, {16'h4444, last_lo});

    // R6: byte load refused, result and kept upper half unchanged
    op(2'b1, 0, 1, 8'h00, 0);
    chk("R6 byte load error", o_err, 1);
    chk("R6 byte load no read", o_re, 0);
    chk("R9 result held after byte load", o_rdata, 16'h2222);
    op(1, 0, 0, 8'h06, 0);
    chk("R6 kept upper unchanged", o_rdata, 16'h2222);

    // R7: read and write together
    op(1, 1, 0, 8'h06, 16'h9999);
    chk("R7 both strobes error", o_err, 1);
    chk("R7 no write", o_we, 0);
    chk("R7 no read", o_re, 0);
    chk("R9 result held after refused access", o_rdata, 16'h2222);
    op(0, 1, 0, 8'h06, 16'h3333);
    chk("R7 parked lower kept", o_wdata, {16'h3333, last_lo});

    // R5: back-to-back low then high load returns one snapshot
    @(negedge clk);
    bus_rd = 1; bus_addr = 8'h04;
    @(negedge clk);
    bus_addr = 8'h06;
    @(negedge clk);
    bus_rd = 0;
    chk("R4 back-to-back low result", bus_rdata, 16'hBEEF);
    @(negedge clk);
    chk("R5 back-to-back upper result", bus_rdata, 16'h3333);
    repeat (3) @(negedge clk);
    chk("R9 result held while idle", bus_rdata, 16'h3333);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule